// File: doc/BRIEF.md
# Expansion Bus Slave Port

This block is the slave side of a 16-bit, asynchronous-style expansion bus, sampled with the local clock. It watches the address strobe, the read line, the 23-bit word address, the two byte-lane strobes and the function code lines. From these inputs it decides whether the current cycle targets this board and turns each access into a single-cycle request to a small local register file. Reads are returned on the data bus when the bus controller allows it. Writes update only the byte lanes that the master selected.

Every access starts when a data strobe falls while the address strobe is low. A master can hold the address strobe low for a locked read-modify-write. The port then treats each new fall of the data strobes as a separate access and raises a lock flag. While an access is waiting for the register file, the port asks for wait states. When the address strobe rises, it releases all the outputs it drives. For reads, the port marks the byte enables differently for the cacheable memory half of the board window and for the I/O half.

Top module: `xbus_slave`

## Requirements
- R1: `sel_o` is high in the cycle after a sampled edge at which `as_ni` is low and `addr_i[22:16]` (address lines 23..17) equals the parameter `BASE`. At every other sampled edge it goes low.
- R2: When `bgack_ni` is high (the processor owns the bus), a cycle with `fc_i` = 3'b111 is not selected. When `bgack_ni` is low, `fc_i` is ignored.
- R3: An access starts at the first sampled edge with `as_ni` low, a hit, and at least one data strobe low. After that edge, `wr_stb_o` (if `read_i` is low) or `rd_stb_o` (if `read_i` is high) is high for exactly one cycle. Within `be_o`, bit 0 is lane D7..D0 and follows `lds_ni`, and bit 1 is lane D15..D8 and follows `uds_ni`, both active low.
- R4: A write updates only the enabled lanes of register `addr_i[3:0]`, one edge after its write strobe. The other lanes keep their old value.
- R5: For a read with `addr_i[15]` = 0 (memory half), `be_o` is 2'b11 whatever the strobes are. For a read with `addr_i[15]` = 1 (I/O half), `be_o` carries the strobes.
- R6: `data_oe_o` is high only for a selected read whose data is ready, while `doe_i` is high and `as_ni` is low. While it is high, `data_o` holds the full addressed register word. While it is low, `data_o` is zero.
- R7: `data_oe_o` drops in the same cycle that `as_ni` goes high. `sel_o` and `wait_o` drop after the next edge.
- R8: If the data strobes rise and fall again while `as_ni` stays low, the second fall starts a new access, and `rmw_o` goes high after that access's start edge. `rmw_o` stays high until `as_ni` is sampled high.
- R9: `wait_o` is high while `sel_o` is high and the current access is not complete. It goes low one edge after the access's strobe.
- R10: After reset, `sel_o`, `wait_o`, `rmw_o`, both strobes and `data_oe_o` are low, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_ni | input | 1 | Address strobe, active low |
| read_i | input | 1 | High for read, low for write |
| addr_i | input | 23 | Word address, lines 23..1 |
| uds_ni | input | 1 | Strobe for lane D15..D8, active low |
| lds_ni | input | 1 | Strobe for lane D7..D0, active low |
| fc_i | input | 3 | Function code lines |
| bgack_ni | input | 1 | Bus grant acknowledge, active low |
| doe_i | input | 1 | Data output enable from the bus controller |
| data_i | input | 16 | Write data from the bus |
| data_o | output | 16 | Read data to the bus |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| sel_o | output | 1 | Board selected |
| wait_o | output | 1 | Wait-state request |
| rmw_o | output | 1 | Locked read-modify-write seen |
| wr_stb_o | output | 1 | Single-cycle write request |
| rd_stb_o | output | 1 | Single-cycle read request |
| be_o | output | 2 | Byte enables of the current request |

## Verification
The assertions check on every cycle that the strobes last one cycle and never overlap, and that the drive enable follows the output-enable input and drops as soon as the address strobe rises. They also check that a memory-half read requests both lanes, that the lock flag holds through the locked sequence, and that the wait request drops after each strobe. Only the bench's scenarios can show the register contents after masked writes, decode misses and function-code rejection. The same holds for the read data word and for the lock flag appearing on the second access of a held strobe.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int unsigned LANES = 2;
  typedef logic [LANES-1:0] lane_t;
  localparam logic [2:0] FC_CPU_SPACE = 3'b111;

  function automatic lane_t strobe_lanes(input logic uds_n, input logic lds_n);
    return {~uds_n, ~lds_n};
  endfunction
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned BASE_W = 7,
  parameter logic [BASE_W-1:0] BASE = 7'h06
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic              bgack_ni,
  output logic              hit_o,
  output logic              io_o
);
  import xbus_pkg::*;
  localparam int unsigned IO_BIT = ADDR_W - BASE_W - 1;

  logic base_match, space_ok;

  assign base_match = (addr_i[ADDR_W-1 -: BASE_W] == BASE);
  // fc only meaningful when the processor owns the bus
  assign space_ok   = !bgack_ni || (fc_i != FC_CPU_SPACE);
  assign hit_o      = base_match && space_ok;
  assign io_o       = addr_i[IO_BIT];
endmodule

// File: rtl/xbus_cycle_trk.sv
module xbus_cycle_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_ni,
  input  logic ds_any_i,
  input  logic hit_i,
  input  logic read_i,
  output logic start_o,
  output logic sel_o,
  output logic wait_o,
  output logic rmw_o,
  output logic wr_stb_o,
  output logic rd_stb_o
);
  logic sel_q, served_q, seen_q, rmw_q, ready_q, wr_q, rd_q;

  assign start_o = !as_ni && ds_any_i && !served_q && hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= 1'b0;
      served_q <= 1'b0;
      seen_q   <= 1'b0;
      rmw_q    <= 1'b0;
      ready_q  <= 1'b0;
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      sel_q    <= !as_ni && hit_i;
      served_q <= !as_ni && ds_any_i;
      seen_q   <= !as_ni && (seen_q || start_o);
      // second strobe fall under one held address strobe marks a locked sequence
      rmw_q    <= !as_ni && (rmw_q || (start_o && seen_q));
      ready_q  <= !as_ni && ds_any_i && (ready_q || wr_q || rd_q);
      wr_q     <= start_o && !read_i;
      rd_q     <= start_o && read_i;
    end
  end

  assign sel_o    = sel_q;
  assign wait_o   = sel_q && !ready_q;
  assign rmw_o    = rmw_q;
  assign wr_stb_o = wr_q;
  assign rd_stb_o = rd_q;

  assert_stb_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_q && rd_q));
  assert_stb_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q || rd_q) |=> !(wr_q || rd_q));
  assert_rmw_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rmw_q && !as_ni) |=> rmw_q);
  assert_wait_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q || rd_q) |=> !wait_o);
  assert_sel_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |=> !sel_q);
endmodule

// File: rtl/xbus_regfile.sv
module xbus_regfile #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned DW    = 16,
  localparam int unsigned IDX_W = $clog2(NREGS),
  localparam int unsigned NL    = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [NL-1:0]    be_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] regs_q [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    for (genvar l = 0; l < NL; l++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[r][l*8 +: 8] <= '0;
        else if (we_i && be_i[l] && (idx_i == IDX_W'(r)))
          regs_q[r][l*8 +: 8] <= wdata_i[l*8 +: 8];
      end
    end
  end

  assign rdata_o = regs_q[idx_i];
endmodule

// File: rtl/xbus_slave.sv
module xbus_slave #(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned DW     = 16,
  parameter int unsigned BASE_W = 7,
  parameter logic [BASE_W-1:0] BASE = 7'h06,
  parameter int unsigned NREGS  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_ni,
  input  logic              read_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              uds_ni,
  input  logic              lds_ni,
  input  logic [2:0]        fc_i,
  input  logic              bgack_ni,
  input  logic              doe_i,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o,
  output logic              sel_o,
  output logic              wait_o,
  output logic              rmw_o,
  output logic              wr_stb_o,
  output logic              rd_stb_o,
  output logic [1:0]        be_o
);
  import xbus_pkg::*;
  localparam int unsigned IDX_W = $clog2(NREGS);

  logic hit, io, start, ds_any;
  lane_t be_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0] wdata_q, rdata, rd_q;
  logic read_q, io_q, rd_valid_q;

  assign ds_any = !uds_ni || !lds_ni;

  xbus_decode #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .BASE(BASE)) u_dec (
    .addr_i(addr_i), .fc_i(fc_i), .bgack_ni(bgack_ni), .hit_o(hit), .io_o(io)
  );

  xbus_cycle_trk u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .as_ni(as_ni), .ds_any_i(ds_any),
    .hit_i(hit), .read_i(read_i), .start_o(start), .sel_o(sel_o),
    .wait_o(wait_o), .rmw_o(rmw_o), .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_q    <= '0;
      idx_q   <= '0;
      wdata_q <= '0;
      read_q  <= 1'b0;
      io_q    <= 1'b0;
    end else if (start) begin
      // memory-half reads are cacheable: always whole word
      be_q    <= (read_i && !io) ? lane_t'(2'b11) : strobe_lanes(uds_ni, lds_ni);
      idx_q   <= addr_i[IDX_W-1:0];
      wdata_q <= data_i;
      read_q  <= read_i;
      io_q    <= io;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q       <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (rd_stb_o) rd_q <= rdata;
      rd_valid_q <= !as_ni && ds_any && (rd_valid_q || rd_stb_o);
    end
  end

  xbus_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_stb_o), .idx_i(idx_q),
    .be_i(be_q), .wdata_i(wdata_q), .rdata_o(rdata)
  );

  assign be_o      = be_q;
  assign data_oe_o = sel_o && read_q && rd_valid_q && doe_i && !as_ni;
  assign data_o    = data_oe_o ? rd_q : '0;

  assert_oe_doe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (doe_i && sel_o));
  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |-> !data_oe_o);
  assert_mem_be_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_o && !io_q) |-> (be_o == 2'b11));
endmodule

// File: tb/xbus_slave_tb.sv
module xbus_slave_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [6:0] BASE = 7'h06;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic as_ni = 1'b1, read_i = 1'b1, uds_ni = 1'b1, lds_ni = 1'b1;
  logic [22:0] addr_i = '0;
  logic [2:0] fc_i = 3'b101;
  logic bgack_ni = 1'b1, doe_i = 1'b1;
  logic [15:0] data_i = '0, data_o;
  logic data_oe_o, sel_o, wait_o, rmw_o, wr_stb_o, rd_stb_o;
  logic [1:0] be_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_slave dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .as_ni(as_ni), .read_i(read_i), .addr_i(addr_i),
    .uds_ni(uds_ni), .lds_ni(lds_ni), .fc_i(fc_i), .bgack_ni(bgack_ni), .doe_i(doe_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .sel_o(sel_o),
    .wait_o(wait_o), .rmw_o(rmw_o), .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o), .be_o(be_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] mk_addr(input logic [6:0] base, input bit io, input logic [3:0] idx);
    logic [22:0] a;
    a = {base, io, 15'(int'($urandom) & 32'h7ff0)};
    a[3:0] = idx;
    return a;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] be);
    return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
  endfunction

  function automatic bit is_hit(input logic [22:0] a, input logic [2:0] fc, input logic bg_n);
    return (a[22:16] == BASE) && (!bg_n || fc != 3'b111);
  endfunction

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [22:0] a, input logic [1:0] be, input logic [15:0] d);
    bit h;
    h = is_hit(a, fc_i, bgack_ni);
    addr_i = a; read_i = 0; as_ni = 0; data_i = d;
    nxt();
    chk(sel_o == h, "R1 sel on write", sel_o, h);
    chk(wait_o == h, "R9 wait before strobe", wait_o, h);
    uds_ni = ~be[1]; lds_ni = ~be[0];
    nxt();
    chk(wr_stb_o == h && rd_stb_o == 0, "R3 write strobe", wr_stb_o, h);
    if (h) chk(be_o == be, "R3 write lanes", be_o, be);
    nxt();
    chk(wr_stb_o == 0, "R3 strobe single", wr_stb_o, 0);
    chk(wait_o == 0, "R9 wait drop", wait_o, 0);
    as_ni = 1; uds_ni = 1; lds_ni = 1;
    nxt();
    chk(sel_o == 0 && wait_o == 0, "R7 release", {sel_o, wait_o}, 0);
    if (h) model[a[3:0]] = merge(model[a[3:0]], d, be);
  endtask

  task automatic bus_read(input logic [22:0] a, input logic [1:0] be, input bit doe);
    bit h;
    logic [1:0] exp_be;
    h = is_hit(a, fc_i, bgack_ni);
    exp_be = a[15] ? be : 2'b11;
    addr_i = a; read_i = 1; as_ni = 0; doe_i = doe;
    uds_ni = ~be[1]; lds_ni = ~be[0];
    nxt();
    chk(rd_stb_o == h && sel_o == h, "R1 R3 read strobe and select", {rd_stb_o, sel_o}, {h, h});
    if (h) chk(be_o == exp_be, "R5 read lanes", be_o, exp_be);
    nxt();
    chk(data_oe_o == (h && doe), "R6 drive enable", data_oe_o, h && doe);
    if (h && doe) chk(data_o == model[a[3:0]], "R4 R6 read data", data_o, model[a[3:0]]);
    else chk(data_o == 0, "R6 idle data", data_o, 0);
    as_ni = 1; uds_ni = 1; lds_ni = 1;
    #1;
    chk(data_oe_o == 0, "R7 immediate release", data_oe_o, 0);
    nxt();
    doe_i = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) nxt();
    chk(sel_o == 0 && wait_o == 0 && rmw_o == 0, "R10 reset flags", {sel_o, wait_o, rmw_o}, 0);
    chk(wr_stb_o == 0 && rd_stb_o == 0 && data_oe_o == 0, "R10 reset strobes",
        {wr_stb_o, rd_stb_o, data_oe_o}, 0);
    rst_ni = 1;
    nxt();
    bus_read(mk_addr(BASE, 0, 4'd5), 2'b11, 1);  // R10 zero contents
    // directed R4 masked writes
    bus_write(mk_addr(BASE, 1, 4'd2), 2'b11, 16'hA55A);
    bus_write(mk_addr(BASE, 1, 4'd2), 2'b01, 16'h12C3);
    bus_write(mk_addr(BASE, 1, 4'd2), 2'b10, 16'h7E00);
    bus_read(mk_addr(BASE, 1, 4'd2), 2'b01, 1);
    bus_read(mk_addr(BASE, 0, 4'd2), 2'b10, 1);   // R5 memory half forces both lanes
    // R1 decode miss leaves contents alone
    bus_write(mk_addr(BASE ^ 7'h01, 0, 4'd2), 2'b11, 16'hFFFF);
    bus_read(mk_addr(BASE, 0, 4'd2), 2'b11, 1);
    // R2 function-code qualification
    fc_i = 3'b111;
    bus_write(mk_addr(BASE, 0, 4'd7), 2'b11, 16'hBEEF);
    bgack_ni = 0;
    bus_write(mk_addr(BASE, 0, 4'd8), 2'b11, 16'hCAFE);
    bgack_ni = 1; fc_i = 3'b101;
    bus_read(mk_addr(BASE, 0, 4'd7), 2'b11, 1);
    bus_read(mk_addr(BASE, 0, 4'd8), 2'b11, 1);
    // R6 doe low
    bus_read(mk_addr(BASE, 1, 4'd8), 2'b11, 0);
    // R8 locked read-modify-write
    addr_i = mk_addr(BASE, 1, 4'd9); read_i = 1; as_ni = 0; uds_ni = 0; lds_ni = 0;
    nxt(); nxt();
    chk(rmw_o == 0, "R8 no lock on first access", rmw_o, 0);
    uds_ni = 1; lds_ni = 1;
    nxt();
    chk(wait_o == 1, "R9 wait rearmed between locked accesses", wait_o, 1);
    read_i = 0; data_i = 16'h3C3C; uds_ni = 1; lds_ni = 0;
    nxt();
    chk(wr_stb_o == 1 && rmw_o == 1, "R8 second access and lock", {wr_stb_o, rmw_o}, 2'b11);
    nxt();
    chk(rmw_o == 1, "R8 lock held", rmw_o, 1);
    model[9] = merge(model[9], 16'h3C3C, 2'b01);
    as_ni = 1; uds_ni = 1; lds_ni = 1;
    nxt();
    chk(rmw_o == 0, "R8 lock clears", rmw_o, 0);
    bus_read(mk_addr(BASE, 0, 4'd9), 2'b11, 1);
    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [1:0] be;
      logic [6:0] b;
      b = ($urandom % 8 == 0) ? 7'($urandom) : BASE;
      be = 2'($urandom % 3 + 1);
      if ($urandom % 2) bus_write(mk_addr(b, 1'($urandom), 4'($urandom)), be, 16'($urandom));
      else bus_read(mk_addr(b, 1'($urandom), 4'($urandom)), be, ($urandom % 4) != 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule